// File: doc/BRIEF.md
# Packed Binary64 Horizontal Difference Engine

This block takes two source vectors of 64-bit IEEE 754 binary64 elements and produces a vector in which each result lane holds the difference of two neighbouring elements taken from one source. Within every 128-bit slice, the low result lane takes the first source and the high result lane takes the second source. In each case the upper element of the pair is subtracted from the lower one. A mode input selects one of three behaviours. Two of them work on 128 bits and differ in what happens to the destination bits above 127. The third works on all 256 bits.

A single binary64 subtractor is shared by all lanes. After a one-cycle `start`, the lanes are worked through in ascending order, one per clock. `done` pulses for one cycle when the last active lane has been written. Every subtraction rounds to nearest-even and handles subnormals fully, with no flush to zero. Exception flags are ORed across the active lanes and stay valid until the next accepted start. In the 128-bit mode that keeps the old upper bits, a misaligned memory operand is reported as a fault and no result is written.

Top module: `hsub_pd_unit`

## Requirements
- R1: In every mode, result bits [63:0] equal src1[63:0] − src1[127:64], and result bits [127:64] equal src2[63:0] − src2[127:64].
- R2: When mode is 2'b10 or 2'b11 (256-bit), result bits [191:128] equal src1[191:128] − src1[255:192], and result bits [255:192] equal src2[191:128] − src2[255:192].
- R3: When mode is 2'b00 (legacy 128-bit), dest_out[255:128] equals dest_in[255:128] as sampled at the accepted start.
- R4: When mode is 2'b01 (zeroing 128-bit), dest_out[255:128] is zero.
- R5: Each difference is binary64 rounded to nearest-even, with subnormal inputs and results kept exact (no flushing). A zero difference of two finite values of unlike effective sign is +0, and (−0) − (+0) gives −0.
- R6: A signalling NaN operand, or the subtraction of two infinities of the same sign, sets invalid (flags[0]). A NaN operand is returned with its quiet bit (bit 51) set, and the first operand's NaN takes precedence. An invalid result that has no NaN operand is 64'h7FF8_0000_0000_0000.
- R7: A finite difference whose rounded magnitude exceeds the largest finite value returns an infinity of the result sign and sets overflow (flags[2]) and inexact (flags[4]). Any rounding error sets inexact. Underflow (flags[3]) is set only when a result is tiny before rounding and inexact.
- R8: Denormal (flags[1]) is set when any operand of any active lane is subnormal. flags is the OR over all active lanes, is cleared at an accepted start, and holds until the next one.
- R9: In mode 2'b00, with mem_op high and mem_addr[3:0] nonzero, fault rises and done pulses on the second clock after start. dest_out and flags keep their previous values. In every other mode, or with mem_op low, alignment is ignored and fault is low.
- R10: done is a one-cycle pulse that comes lanes+1 clocks after the start is sampled (3 for 128-bit modes, 5 for 256-bit). busy is high in between, and a start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| mode | input | 2 | 00 legacy 128, 01 zeroing 128, 1x 256-bit |
| src1 | input | 256 | First source vector |
| src2 | input | 256 | Second source vector |
| dest_in | input | 256 | Prior destination contents |
| mem_op | input | 1 | Second source comes from memory |
| mem_addr | input | 48 | Memory operand address for alignment check |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Misaligned legacy memory operand; held until next start |
| dest_out | output | 256 | Result vector |
| flags | output | 5 | {inexact, underflow, overflow, denormal, invalid} |

## Verification
Sixteen boundary operands are swept over all ordered pairs. The sweep covers signed zeros, both subnormal extremes, the smallest normal, the largest finite value, infinities, and quiet and signalling NaNs. Each pair is run once through the lowest lane and once through the highest lane, while the other lanes compute 1−1 so that any flag from them would show. A design that dropped the sticky bit, flushed subnormals, took the wrong NaN or gave −0 for exact cancellation would fail against the arithmetic model in the bench. A design that selected its operands from the wrong source or element would put the swept difference into the wrong lane. Random cancellation-heavy operands exercise normalisation and rounding carries. Separate tests cover the upper-half policy of each mode, a fault that must leave the previous result and flags untouched, a start pulse held across a busy operation, and the done latency.

// File: rtl/hsub_pkg.sv
package hsub_pkg;
    localparam int ELEM_W  = 64;
    localparam int EXP_W   = 11;
    localparam int FRAC_W  = 52;
    localparam int MANT_W  = FRAC_W + 1;
    localparam int XW      = MANT_W + 3;
    localparam int FL_W    = 5;

    localparam int FL_INV = 0;
    localparam int FL_DEN = 1;
    localparam int FL_OVF = 2;
    localparam int FL_UNF = 3;
    localparam int FL_INX = 4;

    localparam logic [1:0] MODE_LEG128 = 2'b00;
    localparam logic [1:0] MODE_ZER128 = 2'b01;

    localparam logic [EXP_W-1:0] EXP_ALL1 = '1;
    localparam logic [ELEM_W-1:0] DEFAULT_QNAN = 64'h7FF8_0000_0000_0000;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FLT  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/hsub_fp64_sub.sv
module hsub_fp64_sub
    import hsub_pkg::*;
(
    input  logic [ELEM_W-1:0] op_a,
    input  logic [ELEM_W-1:0] op_b,
    output logic [ELEM_W-1:0] diff,
    output logic [FL_W-1:0]   fl
);
    logic              sa, sbn, swap, eff_sub, big_s;
    logic              a_nan, b_nan, a_snan, b_snan, a_inf, b_inf, a_sub, b_sub;
    logic [62:0]       big_m, sml_m;
    logic [EXP_W-1:0]  big_e, sml_e, dsh;
    logic [XW-1:0]     big_x, sml_x, sml_al, mask, norm;
    logic [XW:0]       sum;
    logic [12:0]       exp_w, lim, sh;
    logic [5:0]        lz;
    logic [MANT_W:0]   mant_r;
    logic              g, r, st, up, inx;

    always_comb begin
        sa     = op_a[63];
        sbn    = ~op_b[63];
        a_nan  = (op_a[62:52] == EXP_ALL1) && (op_a[51:0] != '0);
        b_nan  = (op_b[62:52] == EXP_ALL1) && (op_b[51:0] != '0);
        a_snan = a_nan && !op_a[51];
        b_snan = b_nan && !op_b[51];
        a_inf  = (op_a[62:52] == EXP_ALL1) && (op_a[51:0] == '0);
        b_inf  = (op_b[62:52] == EXP_ALL1) && (op_b[51:0] == '0);
        a_sub  = (op_a[62:52] == '0) && (op_a[51:0] != '0);
        b_sub  = (op_b[62:52] == '0) && (op_b[51:0] != '0);

        // order by magnitude so the aligned subtraction never goes negative
        swap    = op_b[62:0] > op_a[62:0];
        big_m   = swap ? op_b[62:0] : op_a[62:0];
        sml_m   = swap ? op_a[62:0] : op_b[62:0];
        big_s   = swap ? sbn : sa;
        eff_sub = sa ^ sbn;
        big_e   = (big_m[62:52] == '0) ? EXP_W'(1) : big_m[62:52];
        sml_e   = (sml_m[62:52] == '0) ? EXP_W'(1) : sml_m[62:52];
        dsh     = big_e - sml_e;
        big_x   = {(big_m[62:52] != '0), big_m[51:0], 3'b000};
        sml_x   = {(sml_m[62:52] != '0), sml_m[51:0], 3'b000};

        mask = '0;
        if (dsh >= EXP_W'(XW)) begin
            sml_al = {{(XW-1){1'b0}}, |sml_x};
        end else begin
            mask   = (XW'(1) << dsh[5:0]) - XW'(1);
            sml_al = (sml_x >> dsh[5:0]) | {{(XW-1){1'b0}}, |(sml_x & mask)};
        end

        sum = eff_sub ? ({1'b0, big_x} - {1'b0, sml_al})
                      : ({1'b0, big_x} + {1'b0, sml_al});

        lz = '0;
        for (int i = 0; i < XW; i++) begin
            if (sum[i]) lz = 6'(XW - 1 - i);
        end

        exp_w = {2'b00, big_e};
        lim   = exp_w - 13'd1;
        sh    = '0;
        if (sum[XW]) begin
            norm  = {sum[XW:2], sum[1] | sum[0]};
            exp_w = exp_w + 13'd1;
        end else begin
            sh    = (13'(lz) < lim) ? 13'(lz) : lim;
            norm  = sum[XW-1:0] << sh[5:0];
            exp_w = exp_w - sh;
        end

        g      = norm[2];
        r      = norm[1];
        st     = norm[0];
        inx    = g | r | st;
        up     = g & (r | st | norm[3]);
        mant_r = {1'b0, norm[XW-1:3]} + (MANT_W+1)'(up);
        if (mant_r[MANT_W]) begin
            mant_r = mant_r >> 1;
            exp_w  = exp_w + 13'd1;
        end

        fl         = '0;
        fl[FL_DEN] = a_sub | b_sub;
        if (a_nan || b_nan) begin
            fl[FL_INV] = a_snan | b_snan;
            diff       = a_nan ? (op_a | 64'h0008_0000_0000_0000)
                               : (op_b | 64'h0008_0000_0000_0000);
        end else if (a_inf && b_inf && (op_a[63] == op_b[63])) begin
            fl[FL_INV] = 1'b1;
            diff       = DEFAULT_QNAN;
        end else if (a_inf) begin
            diff = op_a;
        end else if (b_inf) begin
            diff = {sbn, op_b[62:0]};
        end else if (sum == '0) begin
            diff = {sa & sbn, 63'b0};
        end else if (exp_w >= 13'd2047) begin
            diff       = {big_s, EXP_ALL1, 52'b0};
            fl[FL_OVF] = 1'b1;
            fl[FL_INX] = 1'b1;
        end else begin
            diff       = {big_s, (mant_r[FRAC_W] ? exp_w[EXP_W-1:0] : EXP_W'(0)), mant_r[FRAC_W-1:0]};
            fl[FL_INX] = inx;
            fl[FL_UNF] = inx & !norm[XW-1];
        end
    end
endmodule

// File: rtl/hsub_lane_mux.sv
module hsub_lane_mux
    import hsub_pkg::*;
#(
    parameter int VEC_W  = 256,
    parameter int LANE_W = 2
) (
    input  logic [VEC_W-1:0]  src1,
    input  logic [VEC_W-1:0]  src2,
    input  logic [LANE_W-1:0] lane,
    output logic [ELEM_W-1:0] op_a,
    output logic [ELEM_W-1:0] op_b
);
    localparam int LANES  = VEC_W / ELEM_W;
    localparam int PAIR_W = 2 * ELEM_W;

    logic [ELEM_W-1:0] lo_tab [LANES];
    logic [ELEM_W-1:0] hi_tab [LANES];

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            if (k % 2 == 0) begin : g_from_first
                assign lo_tab[k] = src1[PAIR_W*(k/2) +: ELEM_W];
                assign hi_tab[k] = src1[PAIR_W*(k/2) + ELEM_W +: ELEM_W];
            end else begin : g_from_second
                assign lo_tab[k] = src2[PAIR_W*(k/2) +: ELEM_W];
                assign hi_tab[k] = src2[PAIR_W*(k/2) + ELEM_W +: ELEM_W];
            end
        end
    endgenerate

    assign op_a = lo_tab[lane];
    assign op_b = hi_tab[lane];
endmodule

// File: rtl/hsub_pd_unit.sv
module hsub_pd_unit
    import hsub_pkg::*;
#(
    parameter int VEC_W       = 256,
    parameter int ADDR_W      = 48,
    parameter int ALIGN_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [VEC_W-1:0]  src1,
    input  logic [VEC_W-1:0]  src2,
    input  logic [VEC_W-1:0]  dest_in,
    input  logic              mem_op,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [VEC_W-1:0]  dest_out,
    output logic [FL_W-1:0]   flags
);
    localparam int LANES      = VEC_W / ELEM_W;
    localparam int LANE_W     = $clog2(LANES);
    localparam int HALF_W     = VEC_W / 2;
    localparam int ALIGN_BITS = $clog2(ALIGN_BYTES);

    typedef struct packed {
        seq_state_t        state;
        logic [LANE_W-1:0] lane;
        logic [1:0]        mode;
        logic [VEC_W-1:0]  src1;
        logic [VEC_W-1:0]  src2;
        logic [VEC_W-1:0]  res;
        logic [FL_W-1:0]   flags;
        logic              done;
        logic              fault;
    } regs_t;

    regs_t q, d;
    logic [ELEM_W-1:0] op_a, op_b, lane_res;
    logic [FL_W-1:0]   lane_fl;
    logic [LANE_W-1:0] last_lane;
    logic              misaligned;

    hsub_lane_mux #(.VEC_W(VEC_W), .LANE_W(LANE_W)) u_mux (
        .src1 (q.src1),
        .src2 (q.src2),
        .lane (q.lane),
        .op_a (op_a),
        .op_b (op_b)
    );

    hsub_fp64_sub u_sub (
        .op_a (op_a),
        .op_b (op_b),
        .diff (lane_res),
        .fl   (lane_fl)
    );

    assign last_lane  = q.mode[1] ? LANE_W'(LANES - 1) : LANE_W'(1);
    assign misaligned = (mode == MODE_LEG128) && mem_op && (mem_addr[ALIGN_BITS-1:0] != '0);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.src1  = src1;
                    d.src2  = src2;
                    d.mode  = mode;
                    d.fault = misaligned;
                    if (misaligned) begin
                        d.state = ST_FLT;
                    end else begin
                        d.state = ST_RUN;
                        d.lane  = '0;
                        d.flags = '0;
                        d.res   = '0;
                        if (mode == MODE_LEG128) d.res[VEC_W-1:HALF_W] = dest_in[VEC_W-1:HALF_W];
                    end
                end
            end
            ST_RUN: begin
                d.res[ELEM_W*q.lane +: ELEM_W] = lane_res;
                d.flags = q.flags | lane_fl;
                d.lane  = q.lane + LANE_W'(1);
                if (q.lane == last_lane) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                end
            end
            ST_FLT: begin
                d.state = ST_IDLE;
                d.done  = 1'b1;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = (q.state != ST_IDLE);
    assign done     = q.done;
    assign fault    = q.fault;
    assign dest_out = q.res;
    assign flags    = q.flags;

    assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_lane_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RUN) |-> (q.lane <= last_lane));
    assert_zero_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && q.mode == MODE_ZER128) |-> (dest_out[VEC_W-1:HALF_W] == '0));
    assert_fault_no_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> ($stable(dest_out) && $stable(flags)));
    assert_ovf_inexact_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flags[FL_OVF] |-> flags[FL_INX]);
    assert_unf_inexact_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flags[FL_UNF] |-> flags[FL_INX]);
endmodule

// File: tb/hsub_pd_unit_test.sv
module hsub_pd_unit_test;
    localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] QBIT = 64'h0008_0000_0000_0000;
    localparam logic [63:0] DNAN = 64'h7FF8_0000_0000_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [255:0] src1 = '0, src2 = '0, dest_in = '0;
    logic         mem_op = 1'b0;
    logic [47:0]  mem_addr = '0;
    logic         busy, done, fault;
    logic [255:0] dest_out;
    logic [4:0]   flags;

    int checks = 0;
    int errors = 0;
    logic [63:0] tv [16];

    always #5 clk = ~clk;

    hsub_pd_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .src1(src1), .src2(src2),
        .dest_in(dest_in), .mem_op(mem_op), .mem_addr(mem_addr), .busy(busy), .done(done),
        .fault(fault), .dest_out(dest_out), .flags(flags)
    );

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic is_nan(input logic [63:0] x);
        return (x[62:52] == 11'h7FF) && (x[51:0] != '0);
    endfunction
    function automatic logic is_inf(input logic [63:0] x);
        return (x[62:52] == 11'h7FF) && (x[51:0] == '0);
    endfunction
    function automatic logic is_sub(input logic [63:0] x);
        return (x[62:52] == 11'h000) && (x[51:0] != '0);
    endfunction

    function automatic void ref_sub(input logic [63:0] a, input logic [63:0] b,
                                    output logic [63:0] y, output logic [4:0] fl);
        real x, nb, s, bp, err;
        fl = '0;
        fl[1] = is_sub(a) | is_sub(b);
        if (is_nan(a) || is_nan(b)) begin
            fl[0] = (is_nan(a) && !a[51]) || (is_nan(b) && !b[51]);
            y = is_nan(a) ? (a | QBIT) : (b | QBIT);
        end else if (is_inf(a) && is_inf(b) && a[63] == b[63]) begin
            fl[0] = 1'b1;
            y = DNAN;
        end else begin
            x  = $bitstoreal(a);
            nb = -$bitstoreal(b);
            s  = x + nb;
            y  = $realtobits(s);
            if (!is_inf(a) && !is_inf(b)) begin
                if (y[62:52] == 11'h7FF) begin
                    fl[2] = 1'b1;
                    fl[4] = 1'b1;
                end else begin
                    bp  = s - x;
                    err = (x - (s - bp)) + (nb - bp);
                    fl[4] = (err != 0.0);
                    fl[3] = fl[4] && (y[62:52] == 11'h000);
                end
            end
        end
    endfunction

    function automatic logic [63:0] rnd_fp();
        logic [63:0] v;
        v = {$urandom, $urandom};
        case ($urandom % 6)
            0: ;
            1: v[62:52] = 11'd960 + 11'($urandom % 128);
            2: v[62:52] = '0;
            3: v[62:52] = 11'h7FD + 11'($urandom % 2);
            4: v[62:52] = 11'($urandom % 3);
            default: v = tv[$urandom % 16];
        endcase
        return v;
    endfunction

    task automatic run_op(input logic [1:0] m, input logic [255:0] s1, input logic [255:0] s2,
                          input logic [255:0] di, input logic mo, input logic [47:0] ad,
                          output int lat);
        @(negedge clk);
        mode = m; src1 = s1; src2 = s2; dest_in = di; mem_op = mo; mem_addr = ad;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int lat;
        logic [63:0] y, pa[4], pb[4];
        logic [4:0]  fl, fo;
        logic [255:0] s1, s2, di, exp_v, prev_v;
        logic [4:0]  prev_f;

        tv[0]  = 64'h0000_0000_0000_0000;
        tv[1]  = 64'h8000_0000_0000_0000;
        tv[2]  = ONE;
        tv[3]  = 64'hBFF0_0000_0000_0000;
        tv[4]  = 64'h3FF8_0000_0000_0000;
        tv[5]  = 64'h0000_0000_0000_0001;
        tv[6]  = 64'h000F_FFFF_FFFF_FFFF;
        tv[7]  = 64'h0010_0000_0000_0000;
        tv[8]  = 64'h7FEF_FFFF_FFFF_FFFF;
        tv[9]  = 64'hFFEF_FFFF_FFFF_FFFF;
        tv[10] = 64'h7FF0_0000_0000_0000;
        tv[11] = 64'hFFF0_0000_0000_0000;
        tv[12] = 64'h7FF8_0000_0000_0001;
        tv[13] = 64'h7FF0_0000_0000_0001;
        tv[14] = 64'hFFF8_0000_0000_0002;
        tv[15] = 64'h3FF0_0000_0000_0001;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset R10 busy/done/fault", {253'b0, busy, done, fault}, '0);
        chk("reset R8 flags", {251'b0, flags}, '0);
        chk("reset R1 dest_out", dest_out, '0);

        // pair sweep through lane 0 in zeroing 128-bit mode (R1 R4 R5 R6 R7 R8)
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                ref_sub(tv[i], tv[j], y, fl);
                s1 = {$urandom, $urandom, $urandom, $urandom, 64'b0, 64'b0};
                s1[127:0] = {tv[j], tv[i]};
                s2 = {128'hFFFF, ONE, ONE};
                di = {8{$urandom}};
                run_op(2'b01, s1, s2, di, 1'b0, '0, lat);
                chk("R1 R4 R5 R6 lane0 sweep result", dest_out, {128'b0, 64'b0, y});
                chk("R7 R8 lane0 sweep flags", {251'b0, flags}, {251'b0, fl});
            end
        end

        // pair sweep through lane 3 in 256-bit mode (R2 R5 R6 R7 R8)
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                ref_sub(tv[i], tv[j], y, fl);
                s1 = {ONE, ONE, ONE, ONE};
                s2 = {tv[j], tv[i], ONE, ONE};
                run_op(2'b10, s1, s2, '1, 1'b0, '0, lat);
                chk("R2 R5 R6 lane3 sweep result", dest_out, {y, 64'b0, 64'b0, 64'b0});
                chk("R7 R8 lane3 sweep flags", {251'b0, flags}, {251'b0, fl});
            end
        end

        // random operands over all four lanes, flags ORed (R2 R5 R7 R8)
        for (int t = 0; t < 200; t++) begin
            fo = '0;
            for (int k = 0; k < 4; k++) begin
                pa[k] = rnd_fp();
                pb[k] = ($urandom % 3 == 0) ? (pa[k] ^ {56'b0, 8'($urandom)}) : rnd_fp();
                ref_sub(pa[k], pb[k], y, fl);
                exp_v[64*k +: 64] = y;
                fo = fo | fl;
            end
            s1 = {pb[2], pa[2], pb[0], pa[0]};
            s2 = {pb[3], pa[3], pb[1], pa[1]};
            run_op((t % 2 == 0) ? 2'b10 : 2'b11, s1, s2, '0, 1'b0, '0, lat);
            chk("R2 R5 random result", dest_out, exp_v);
            chk("R8 random ORed flags", {251'b0, flags}, {251'b0, fo});
            if (t < 4) chk("R10 latency 256-bit", 256'(lat), 256'd5);
        end

        // legacy mode keeps upper destination bits, aligned memory operand (R3 R10)
        di = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        s1 = {128'hABCD, tv[5], tv[4]};
        s2 = {128'h1234, tv[2], tv[8]};
        run_op(2'b00, s1, s2, di, 1'b1, 48'h1000_0000_0010, lat);
        ref_sub(tv[4], tv[5], exp_v[63:0], fl);
        ref_sub(tv[8], tv[2], exp_v[127:64], fo);
        chk("R3 legacy keeps upper", dest_out, {di[255:128], exp_v[127:0]});
        chk("R3 legacy flags", {251'b0, flags}, {251'b0, fl | fo});
        chk("R10 latency 128-bit", 256'(lat), 256'd3);
        chk("R9 aligned no fault", {255'b0, fault}, '0);
        @(negedge clk);
        chk("R10 done one cycle", {255'b0, done}, '0);
        prev_v = dest_out;
        prev_f = flags;

        // misaligned legacy memory operand faults without update (R9)
        run_op(2'b00, {4{ONE}}, {4{tv[15]}}, '1, 1'b1, 48'h0000_0000_0008, lat);
        chk("R9 fault raised", {255'b0, fault}, 256'd1);
        chk("R9 fault latency", 256'(lat), 256'd2);
        chk("R9 dest_out unchanged", dest_out, prev_v);
        chk("R9 flags unchanged", {251'b0, flags}, {251'b0, prev_f});
        @(negedge clk);
        chk("R9 fault held after done", {255'b0, fault}, 256'd1);

        // misalignment ignored outside legacy mode or without memory operand (R9 R4)
        run_op(2'b01, {128'b0, tv[2], tv[4]}, {128'b0, tv[2], tv[2]}, '1, 1'b1, 48'h7, lat);
        chk("R9 zeroing mode ignores alignment", {255'b0, fault}, '0);
        chk("R4 zeroing mode result", dest_out, {128'b0, 64'b0, 64'h3FE0_0000_0000_0000});
        run_op(2'b00, {128'b0, tv[2], tv[4]}, {128'b0, tv[2], tv[2]}, {64'h55, 192'b0}, 1'b0, 48'h3, lat);
        chk("R9 register operand ignores alignment", {255'b0, fault}, '0);
        chk("R3 legacy register operand", dest_out, {64'h55, 64'b0, 64'b0, 64'h3FE0_0000_0000_0000});

        // start held high while busy is ignored (R10)
        @(negedge clk);
        mode = 2'b01; src1 = {128'b0, tv[2], tv[4]}; src2 = {128'b0, tv[2], tv[2]};
        mem_op = 1'b0; start = 1'b1;
        @(negedge clk);
        chk("R10 busy after start", {255'b0, busy}, 256'd1);
        src1 = {128'b0, tv[8], tv[9]};
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R10 done with held start", {255'b0, done}, 256'd1);
        chk("R10 start during busy ignored", dest_out, {128'b0, 64'b0, 64'h3FE0_0000_0000_0000});
        @(negedge clk);
        chk("R10 idle after done", {254'b0, busy, done}, '0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule